// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block keeps the three status flags of a UART-style serial port. The flags are transmit-empty, receive-full and receive-overrun. The transmit and receive datapaths set them with single-cycle strobes. Software clears them with a two-step handshake. A DMA engine that services the data registers clears the data flags as a side effect of its accesses. The block also produces the transmit and receive interrupt requests from the flags and two software enable bits.

Software clears a flag in two steps. First it reads the register while the flag is 1, which arms that flag. Then it writes the register with 0 in that flag's bit. Writing 1 never changes a flag. A flag that became 1 only after the read was not armed, so it survives the write. Any register write consumes every arm, whatever the write does.

When a reception finishes while receive-full is still 1, the block raises overrun and holds back the load strobe to the receive data register, so the new byte is dropped. The bit positions of the flags in the register and the interrupt output style are parameters.

Top module: `serstat_reg`

## Requirements
- R1: After reset, transmit-empty is 1, and receive-full and overrun are 0. With the default layout, the read data places transmit-empty at bit 7, receive-full at bit 6 and overrun at bit 5, and every other bit reads 0, so `rd_data` is 8'h80.
- R2: A register write with a 1 in a flag's bit leaves that flag unchanged. A write never sets a flag that is 0.
- R3: A write with a 0 in a flag's bit clears that flag one cycle later only if that flag is armed. A flag is armed by a register read that returned it as 1 and has had no register write since. Every register write disarms all flags.
- R4: A flag that was 0 at the arming read and is set afterwards stays 1 through the following write of 0.
- R5: Transmit-empty becomes 1 one cycle after `tx_load` pulses, and it is held at 1 for as long as `te` is 0.
- R6: `dma_tx_wr` clears transmit-empty, and `dma_rx_rd` clears receive-full, each one cycle later. Neither strobe changes overrun.
- R7: When `rx_done` is 1 while `re` is 1 and receive-full is 0, `rdr_load` is 1 in that same cycle and receive-full becomes 1 on the next cycle.
- R8: When `rx_done` is 1 while `re` is 1 and receive-full is 1, overrun becomes 1 on the next cycle, `rdr_load` stays 0, and receive-full stays 1.
- R9: While `re` is 0, `rx_done` is ignored: `rdr_load`, receive-full and overrun do not change. Lowering `re` leaves receive-full as it was.
- R10: If a setting event and a clearing event (CPU write or DMA strobe) reach the same flag in the same cycle, the flag is 1 afterwards.
- R11: With `IRQ_REG`=0, `txi` equals transmit-empty AND `tie`, and `rxi` equals receive-full AND `rie`, in the same cycle.
- R12: A setting event between the arming read and the clearing write does not stop that write from clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | CPU read strobe for the status register |
| wr_en | input | 1 | CPU write strobe for the status register |
| wr_data | input | REG_W | CPU write data |
| rd_data | output | REG_W | Status register read value |
| te | input | 1 | Transmitter enable |
| re | input | 1 | Receiver enable |
| tie | input | 1 | Transmit interrupt enable |
| rie | input | 1 | Receive interrupt enable |
| tx_load | input | 1 | Strobe: holding register moved into the shift register |
| rx_done | input | 1 | Strobe: a reception finished without error |
| dma_tx_wr | input | 1 | Strobe: DMA wrote the transmit holding register |
| dma_rx_rd | input | 1 | Strobe: DMA read the receive data register |
| tx_empty | output | 1 | Transmit-empty flag |
| rx_full | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun flag |
| rdr_load | output | 1 | Load enable for the receive data register |
| txi | output | 1 | Transmit interrupt request |
| rxi | output | 1 | Receive interrupt request |

## Verification
The bench uses the default layout: an 8-bit register with flags at bits 7, 6 and 5, and combinational interrupts (`IRQ_REG`=0). Because there are only three flags, the bench can sweep all eight combinations of cleared and kept flags in an armed write. For each combination it computes the expected flags from the write pattern. It also sweeps the four combinations of interrupt enables against both flag states. Directed sequences cover the other cases: a set event landing between the read and the write, a set event and a clear event in the same cycle, and an overrun with the receiver enabled and with it disabled.

// File: rtl/serstat_pkg.sv
package serstat_pkg;
   localparam int NUM_FLAGS = 3;

   typedef enum int unsigned {
      FLG_TXE = 0,
      FLG_RXF = 1,
      FLG_OVR = 2
   } flag_idx_e;

   typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/serstat_flag_cell.sv
// One status flag with its own read-as-one arm bit.
module serstat_flag_cell #(
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_stb,
   input  logic wr_stb,
   input  logic wr_bit,
   input  logic set_evt,
   input  logic dma_clr,
   output logic flag_o
);
   logic flag_q;
   logic arm_q;
   logic cpu_clr;

   assign cpu_clr = wr_stb & ~wr_bit & arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= RESET_VAL;
      end else if (set_evt) begin
         flag_q <= 1'b1;
      end else if (cpu_clr || dma_clr) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
      end else if (rd_stb) begin
         arm_q <= flag_q;
      end else if (wr_stb) begin
         arm_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   // R10: a set event always leaves the flag at 1
   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_o);

   // R2: writing 1 never drops a flag
   assert_write_one_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_bit && !dma_clr && flag_o) |=> flag_o);

   // R3: a flag only falls after a write of 0 or a DMA strobe
   assert_fall_needs_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past((wr_stb && !wr_bit) || dma_clr));
endmodule

// File: rtl/serstat_evt_decode.sv
// Turns datapath and DMA strobes into per-flag set and clear events.
module serstat_evt_decode
   import serstat_pkg::*;
(
   input  logic      te,
   input  logic      re,
   input  logic      tx_load,
   input  logic      rx_done,
   input  logic      dma_tx_wr,
   input  logic      dma_rx_rd,
   input  logic      rx_full_q,
   output flag_vec_t set_o,
   output flag_vec_t dma_clr_o,
   output logic      rdr_load_o
);
   logic rx_accept;

   assign rx_accept = rx_done & re;

   always_comb begin
      set_o              = '0;
      dma_clr_o          = '0;
      set_o[FLG_TXE]     = ~te | tx_load;
      set_o[FLG_RXF]     = rx_accept & ~rx_full_q;
      set_o[FLG_OVR]     = rx_accept & rx_full_q;
      dma_clr_o[FLG_TXE] = dma_tx_wr;
      dma_clr_o[FLG_RXF] = dma_rx_rd;
   end

   assign rdr_load_o = rx_accept & ~rx_full_q;
endmodule

// File: rtl/serstat_reg.sv
module serstat_reg
   import serstat_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int TXE_POS = 7,
   parameter int RXF_POS = 6,
   parameter int OVR_POS = 5,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             te,
   input  logic             re,
   input  logic             tie,
   input  logic             rie,
   input  logic             tx_load,
   input  logic             rx_done,
   input  logic             dma_tx_wr,
   input  logic             dma_rx_rd,
   output logic             tx_empty,
   output logic             rx_full,
   output logic             overrun,
   output logic             rdr_load,
   output logic             txi,
   output logic             rxi
);
   localparam int FLAG_POS [NUM_FLAGS] = '{TXE_POS, RXF_POS, OVR_POS};

   if (REG_W < NUM_FLAGS) begin : g_bad_width
      $error("register narrower than the flag count");
   end
   if (TXE_POS >= REG_W || RXF_POS >= REG_W || OVR_POS >= REG_W ||
       TXE_POS < 0 || RXF_POS < 0 || OVR_POS < 0) begin : g_bad_pos
      $error("flag position outside the register");
   end
   if (TXE_POS == RXF_POS || TXE_POS == OVR_POS || RXF_POS == OVR_POS) begin : g_bad_overlap
      $error("flag positions overlap");
   end

   flag_vec_t flags;
   flag_vec_t set_v;
   flag_vec_t dclr_v;
   logic      unused_wr;

   assign unused_wr = ^wr_data;

   serstat_evt_decode u_decode (
      .te         (te),
      .re         (re),
      .tx_load    (tx_load),
      .rx_done    (rx_done),
      .dma_tx_wr  (dma_tx_wr),
      .dma_rx_rd  (dma_rx_rd),
      .rx_full_q  (flags[FLG_RXF]),
      .set_o      (set_v),
      .dma_clr_o  (dclr_v),
      .rdr_load_o (rdr_load)
   );

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      serstat_flag_cell #(
         .RESET_VAL (g == int'(FLG_TXE))
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_stb  (rd_en),
         .wr_stb  (wr_en),
         .wr_bit  (wr_data[FLAG_POS[g]]),
         .set_evt (set_v[g]),
         .dma_clr (dclr_v[g]),
         .flag_o  (flags[g])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_FLAGS; i++) begin
         rd_data[FLAG_POS[i]] = flags[i];
      end
   end

   assign tx_empty = flags[FLG_TXE];
   assign rx_full  = flags[FLG_RXF];
   assign overrun  = flags[FLG_OVR];

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            txi <= 1'b0;
            rxi <= 1'b0;
         end else begin
            txi <= flags[FLG_TXE] & tie;
            rxi <= flags[FLG_RXF] & rie;
         end
      end
   end else begin : g_irq_comb
      assign txi = flags[FLG_TXE] & tie;
      assign rxi = flags[FLG_RXF] & rie;
   end

   // R5: transmitter disabled keeps transmit-empty high
   assert_te_low_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !te |=> tx_empty);

   // R8: overrun rises only from an accepted completion while full
   assert_ovr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_done && re && rx_full));

   // R9: with the receiver off and no clears, receive flags hold
   assert_re_off_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!re && !dma_rx_rd && !wr_en) |=> ($stable(rx_full) && $stable(overrun)));

   // R7: no load into the receive data register while it is full
   assert_no_load_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> !rdr_load);
endmodule

// File: tb/test_serstat_reg.sv
module test_serstat_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       te = 1'b1, re = 1'b1, tie = 1'b0, rie = 1'b0;
   logic       tx_load = 1'b0, rx_done = 1'b0, dma_tx_wr = 1'b0, dma_rx_rd = 1'b0;
   logic       tx_empty, rx_full, overrun, rdr_load, txi, rxi;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   serstat_reg i_serstat_reg (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .te(te), .re(re),
      .tie(tie), .rie(rie), .tx_load(tx_load), .rx_done(rx_done),
      .dma_tx_wr(dma_tx_wr), .dma_rx_rd(dma_rx_rd), .tx_empty(tx_empty),
      .rx_full(rx_full), .overrun(overrun), .rdr_load(rdr_load),
      .txi(txi), .rxi(rxi)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rd_en = 0; wr_en = 0; wr_data = '0; te = 1; re = 1;
      tx_load = 0; rx_done = 0; dma_tx_wr = 0; dma_rx_rd = 0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic pulse_rx();
      rx_done = 1; tick(); rx_done = 0;
   endtask

   task automatic cpu_read();
      rd_en = 1; tick(); rd_en = 0;
   endtask

   task automatic cpu_write(input logic [7:0] d);
      wr_data = d; wr_en = 1; tick(); wr_en = 0; wr_data = '0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state and layout
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 rx_full", rx_full, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 rd_data", rd_data, 8'h80);

      // R11 interrupt sweep, receive-full low
      for (int k = 0; k < 4; k++) begin
         tie = k[0]; rie = k[1]; #1;
         chk("R11 txi", txi, k[0]);
         chk("R11 rxi", rxi, 0);
      end

      // R7 accepted completion with empty receive register
      rx_done = 1; #1;
      chk("R7 rdr_load", rdr_load, 1);
      tick(); rx_done = 0;
      chk("R7 rx_full", rx_full, 1);

      // R11 interrupt sweep, receive-full high
      for (int k = 0; k < 4; k++) begin
         tie = k[0]; rie = k[1]; #1;
         chk("R11 rxi", rxi, k[1]);
      end
      tie = 0; rie = 0;

      // R8 overrun
      rx_done = 1; #1;
      chk("R8 rdr_load", rdr_load, 0);
      tick(); rx_done = 0;
      chk("R8 overrun", overrun, 1);
      chk("R8 rx_full", rx_full, 1);
      chk("R8 rd_data", rd_data, 8'hE0);

      // R3 write without read clears nothing
      cpu_write(8'h00);
      chk("R3 unarmed", rd_data, 8'hE0);

      // R2 armed write of ones, then R3 arm consumed
      cpu_read();
      cpu_write(8'hFF);
      chk("R2 write ones", rd_data, 8'hE0);
      cpu_write(8'h00);
      chk("R3 arm consumed", rd_data, 8'hE0);

      // R3 exhaustive clear-mask sweep
      for (int m = 0; m < 8; m++) begin
         logic [7:0] d;
         logic [7:0] e;
         do_reset();
         pulse_rx(); pulse_rx();
         cpu_read();
         d = 8'hFF; e = 8'h00;
         if (m[0]) d[7] = 0; else e[7] = 1;
         if (m[1]) d[6] = 0; else e[6] = 1;
         if (m[2]) d[5] = 0; else e[5] = 1;
         cpu_write(d);
         chk("R3 sweep", rd_data, e);
      end

      // R4 flag set after the read survives
      do_reset();
      cpu_read();
      pulse_rx();
      cpu_write(8'h00);
      chk("R4 rx_full kept", rx_full, 1);
      chk("R3 tx_empty cleared", tx_empty, 0);

      // R12 set event between read and write
      do_reset();
      cpu_read();
      tx_load = 1; tick(); tx_load = 0;
      cpu_write(8'h00);
      chk("R12 tx_empty cleared", tx_empty, 0);

      // R5 transmit-empty set sources
      tx_load = 1; tick(); tx_load = 0;
      chk("R5 tx_load", tx_empty, 1);
      dma_tx_wr = 1; tick(); dma_tx_wr = 0;
      chk("R6 dma_tx_wr", tx_empty, 0);
      te = 0; tick();
      chk("R5 te low", tx_empty, 1);
      dma_tx_wr = 1; tick(); dma_tx_wr = 0;
      chk("R10 te low vs dma", tx_empty, 1);
      te = 1;

      // R6 DMA read clears receive-full only
      pulse_rx(); pulse_rx();
      dma_rx_rd = 1; tick(); dma_rx_rd = 0;
      chk("R6 rx_full", rx_full, 0);
      chk("R6 overrun", overrun, 1);

      // R9 receiver disabled
      re = 0;
      rx_done = 1; #1;
      chk("R9 rdr_load", rdr_load, 0);
      tick(); rx_done = 0;
      chk("R9 rx_full", rx_full, 0);
      re = 1; pulse_rx(); re = 0; tick(); tick();
      chk("R9 re low keeps", rx_full, 1);
      do_reset(); pulse_rx(); re = 0;
      pulse_rx();
      chk("R9 no overrun", overrun, 0);
      re = 1;

      // R10 simultaneous set and clear
      cpu_read();
      tx_load = 1; wr_data = 8'h00; wr_en = 1; tick();
      tx_load = 0; wr_en = 0;
      chk("R10 tx write vs load", tx_empty, 1);
      dma_rx_rd = 1; tick(); dma_rx_rd = 0;
      chk("R6 rx cleared", rx_full, 0);
      rx_done = 1; dma_rx_rd = 1; tick(); rx_done = 0; dma_rx_rd = 0;
      chk("R10 rx done vs dma", rx_full, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule